// File: doc/BRIEF.md
# Inter-chip link reset and health sequencer

This block drives the control side of an inter-chip serial link through a register port of a link controller. On a bring-down request it walks a fixed series of register writes. The series turns automatic link training off, puts the PHY core into reset, clears the CRC and status registers, holds the reset for a programmable number of cycles, and then releases the reset. A bring-up request issues one write that turns automatic link training back on. A health-check request reads the link status word. It repeats the read until the word matches the healthy value exactly, or until a try limit is reached.

Every register access follows the same handshake. The sequencer issues a one-cycle request, waits a fixed number of cycles, and then samples the completion inputs. If the access is not complete, it waits and polls again, up to a retry limit. When the retries run out, the sequencer raises a sticky timeout flag and carries on with the rest of the series. A cycle count stands in for the millisecond delays of the real link. One datapath module holds the counters, the flags and the register address and data mux. One control module holds the state machine. The control module drives the datapath through a small struct of strobes.

Top module: `link_seq_top`

## Requirements
- R1: After reset, `busy`, `regReq`, `linkPass`, `linkFail` and `timeoutErr` are all 0.
- R2: In idle, a request is accepted in the cycle it is sampled. If several requests arrive in the same cycle, bring-down wins over bring-up, and bring-up wins over health check. `busy` is 1 from the next cycle.
- R3: Bring-down issues exactly five writes, in this order. The first goes to register 8 with data `SETTINGS_BASE` and bit 1 clear. The second goes to register 7 with `CTRL_BASE` plus bit 24 (host mode) and bit 26 (core reset). The third goes to register 4 with 0. The fourth goes to register 5 with 0. The fifth goes to register 7 with `CTRL_BASE` plus bit 24 only.
- R4: After the fourth write completes, exactly `HOLD_CYCLES` cycles pass with no request before the fifth write is issued.
- R5: After each request, `regReq` stays low for `POLL_WAIT` cycles, and completion is then sampled. A write completes on `regDone`. A read completes on `regDone` and `regDataRdy` together. An incomplete poll waits `POLL_WAIT` cycles again, for at most `MAX_RETRY` polls per access.
- R6: When an access fails all its polls, `timeoutErr` is set and stays set until the next accepted request. The current series still runs to its end.
- R7: Bring-up issues exactly one write, to register 8, with data `SETTINGS_BASE` and bit 1 set.
- R8: A health check reads register 5. `linkPass` is set only if the read word equals exactly 0x0F009000, which is bits 12, 15 and 27:24 set and every other bit clear.
- R9: A health check that does not match re-reads the register, up to `LINK_TRIES` reads. `linkFail` is set after the last read fails.
- R10: Requests that arrive while `busy` is 1 are ignored and have no later effect.
- R11: `busy` falls in the cycle after the final poll of the series. `linkPass`, `linkFail` and `timeoutErr` are cleared when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| downReq | input | 1 | Start the bring-down series |
| upReq | input | 1 | Start the bring-up write |
| checkReq | input | 1 | Start a health check |
| regDone | input | 1 | Link controller reports the current access complete |
| regDataRdy | input | 1 | Read data valid for the current access |
| regRdData | input | DATA_W | Read data from the link controller |
| regReq | output | 1 | One-cycle register access request |
| regWrite | output | 1 | 1 for a write access, 0 for a read |
| regAddr | output | ADDR_W | Register number of the access |
| regWrData | output | DATA_W | Write data of the access |
| busy | output | 1 | A series is in progress |
| linkPass | output | 1 | The last health check matched |
| linkFail | output | 1 | The last health check gave up |
| timeoutErr | output | 1 | An access timed out during the last series |

## Verification
Two kinds of collision can happen in the same cycle. The first is several requests arriving together at idle. The bench raises all three request lines in one cycle, and then only bring-up and check. It judges the result by the first address and data that come out, and by the number of writes. The second is a new request arriving during a poll or hold cycle of a running series. The bench pulses the other request lines in the middle of a bring-down. Its reference model, which ignores requests while busy, must then agree with the port trace on every later cycle. The bench also confirms that only five writes appear.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  typedef enum logic [1:0] {
    OP_DOWN  = 2'd0,
    OP_UP    = 2'd1,
    OP_CHECK = 2'd2
  } seqOpE;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_POLL  = 3'd3,
    ST_HOLD  = 3'd4
  } seqStateE;

  typedef struct packed {
    logic loadOp;
    logic clrFlags;
    logic clrTick;
    logic incTick;
    logic clrRetry;
    logic incRetry;
    logic clrStep;
    logic incStep;
    logic clrTries;
    logic incTries;
    logic setErr;
    logic setPass;
    logic setFail;
  } seqStrobeT;

  // Register numbers decoded by the link controller
  localparam int unsigned REG_CRC      = 4;
  localparam int unsigned REG_STATUS   = 5;
  localparam int unsigned REG_PHY_CTRL = 7;
  localparam int unsigned REG_SETTINGS = 8;

  // Bit positions decoded by the link controller
  localparam int unsigned BIT_AUTOLINK = 1;
  localparam int unsigned BIT_HOST     = 24;
  localparam int unsigned BIT_CORE_RST = 26;

  // Healthy status word: PHY ready, link present, four violation bits set
  localparam logic [31:0] STATUS_GOOD = 32'h0F00_9000;

  // Bring-down series: index of the last write and of the write before the hold
  localparam int unsigned DOWN_LAST = 4;
  localparam int unsigned DOWN_HOLD = 3;

endpackage

// File: rtl/link_seq_datapath.sv
module link_seq_datapath
  import link_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned POLL_WAIT     = 4,
  parameter int unsigned HOLD_CYCLES   = 16,
  parameter int unsigned MAX_RETRY     = 100,
  parameter int unsigned LINK_TRIES    = 100,
  parameter logic [31:0] SETTINGS_BASE = 32'h3000_3510,
  parameter logic [31:0] CTRL_BASE     = 32'h0000_0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  seqOpE             opSel,
  input  logic [DATA_W-1:0] rdData,
  output seqOpE             opCur,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrite,
  output logic              waitDone,
  output logic              holdDone,
  output logic              retryLast,
  output logic              triesLast,
  output logic              stepHold,
  output logic              stepLast,
  output logic              statusMatch,
  output logic              passFlag,
  output logic              failFlag,
  output logic              errFlag
);

  localparam int unsigned TICK_MAX = (POLL_WAIT > HOLD_CYCLES) ? POLL_WAIT : HOLD_CYCLES;
  localparam int unsigned TICK_W   = $clog2(TICK_MAX + 1);
  localparam int unsigned RETRY_W  = $clog2(MAX_RETRY + 1);
  localparam int unsigned TRIES_W  = $clog2(LINK_TRIES + 1);
  localparam int unsigned STEP_W   = $clog2(DOWN_LAST + 1);

  logic [TICK_W-1:0]  tickCnt;
  logic [RETRY_W-1:0] retryCnt;
  logic [TRIES_W-1:0] triesCnt;
  logic [STEP_W-1:0]  stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCur    <= OP_DOWN;
      tickCnt  <= '0;
      retryCnt <= '0;
      triesCnt <= '0;
      stepCnt  <= '0;
      passFlag <= 1'b0;
      failFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strb.loadOp) opCur <= opSel;

      if (strb.clrTick)      tickCnt <= '0;
      else if (strb.incTick) tickCnt <= tickCnt + 1'b1;

      if (strb.clrRetry)      retryCnt <= '0;
      else if (strb.incRetry) retryCnt <= retryCnt + 1'b1;

      if (strb.clrTries)      triesCnt <= '0;
      else if (strb.incTries) triesCnt <= triesCnt + 1'b1;

      if (strb.clrStep)      stepCnt <= '0;
      else if (strb.incStep) stepCnt <= stepCnt + 1'b1;

      if (strb.clrFlags) begin
        passFlag <= 1'b0;
        failFlag <= 1'b0;
        errFlag  <= 1'b0;
      end else begin
        if (strb.setPass) passFlag <= 1'b1;
        if (strb.setFail) failFlag <= 1'b1;
        if (strb.setErr)  errFlag  <= 1'b1;
      end
    end
  end

  assign waitDone    = (tickCnt == TICK_W'(POLL_WAIT - 1));
  assign holdDone    = (tickCnt == TICK_W'(HOLD_CYCLES - 1));
  assign retryLast   = (retryCnt == RETRY_W'(MAX_RETRY - 1));
  assign triesLast   = (triesCnt == TRIES_W'(LINK_TRIES - 1));
  assign stepHold    = (stepCnt == STEP_W'(DOWN_HOLD));
  assign stepLast    = (stepCnt == STEP_W'(DOWN_LAST));
  assign statusMatch = (rdData == DATA_W'(STATUS_GOOD));

  // Address and data of the access selected by operation and step
  logic [31:0] ctrlRun;
  logic [31:0] ctrlReset;
  logic [31:0] settingsOff;
  logic [31:0] settingsOn;

  always_comb begin
    ctrlRun               = CTRL_BASE;
    ctrlRun[BIT_HOST]     = 1'b1;
    ctrlRun[BIT_CORE_RST] = 1'b0;
    ctrlReset             = ctrlRun;
    ctrlReset[BIT_CORE_RST] = 1'b1;
    settingsOff           = SETTINGS_BASE;
    settingsOff[BIT_AUTOLINK] = 1'b0;
    settingsOn            = SETTINGS_BASE;
    settingsOn[BIT_AUTOLINK]  = 1'b1;
  end

  always_comb begin
    regAddr   = ADDR_W'(REG_STATUS);
    regWrData = '0;
    regWrite  = 1'b0;
    unique case (opCur)
      OP_DOWN: begin
        regWrite = 1'b1;
        unique case (stepCnt)
          STEP_W'(0): begin
            regAddr   = ADDR_W'(REG_SETTINGS);
            regWrData = DATA_W'(settingsOff);
          end
          STEP_W'(1): begin
            regAddr   = ADDR_W'(REG_PHY_CTRL);
            regWrData = DATA_W'(ctrlReset);
          end
          STEP_W'(2): begin
            regAddr   = ADDR_W'(REG_CRC);
            regWrData = '0;
          end
          STEP_W'(3): begin
            regAddr   = ADDR_W'(REG_STATUS);
            regWrData = '0;
          end
          default: begin
            regAddr   = ADDR_W'(REG_PHY_CTRL);
            regWrData = DATA_W'(ctrlRun);
          end
        endcase
      end
      OP_UP: begin
        regWrite  = 1'b1;
        regAddr   = ADDR_W'(REG_SETTINGS);
        regWrData = DATA_W'(settingsOn);
      end
      default: begin
        regWrite  = 1'b0;
        regAddr   = ADDR_W'(REG_STATUS);
        regWrData = '0;
      end
    endcase
  end

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(passFlag && failFlag));

  assert_pass_only_check_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passFlag) |-> (opCur == OP_CHECK));

  assert_retry_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt < RETRY_W'(MAX_RETRY));

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= STEP_W'(DOWN_LAST));

endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
  import link_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      downReq,
  input  logic      upReq,
  input  logic      checkReq,
  input  logic      regDone,
  input  logic      regDataRdy,
  input  seqOpE     opCur,
  input  logic      waitDone,
  input  logic      holdDone,
  input  logic      retryLast,
  input  logic      triesLast,
  input  logic      stepHold,
  input  logic      stepLast,
  input  logic      statusMatch,
  output seqStrobeT strb,
  output seqOpE     opSel,
  output logic      regReq,
  output logic      busy
);

  seqStateE state;
  seqStateE stateNext;
  logic     pollOk;

  assign pollOk = regDone && ((opCur != OP_CHECK) || regDataRdy);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    opSel     = downReq ? OP_DOWN : (upReq ? OP_UP : OP_CHECK);
    unique case (state)
      ST_IDLE: begin
        if (downReq || upReq || checkReq) begin
          strb.loadOp   = 1'b1;
          strb.clrFlags = 1'b1;
          strb.clrStep  = 1'b1;
          strb.clrTries = 1'b1;
          stateNext     = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strb.clrTick  = 1'b1;
        strb.clrRetry = 1'b1;
        stateNext     = ST_WAIT;
      end
      ST_WAIT: begin
        strb.incTick = 1'b1;
        if (waitDone) stateNext = ST_POLL;
      end
      ST_POLL: begin
        strb.clrTick = 1'b1;
        if (!pollOk && !retryLast) begin
          strb.incRetry = 1'b1;
          stateNext     = ST_WAIT;
        end else begin
          if (!pollOk) strb.setErr = 1'b1;
          unique case (opCur)
            OP_DOWN: begin
              if (stepLast) begin
                stateNext = ST_IDLE;
              end else begin
                strb.incStep = 1'b1;
                stateNext    = stepHold ? ST_HOLD : ST_ISSUE;
              end
            end
            OP_UP: stateNext = ST_IDLE;
            default: begin
              if (pollOk && statusMatch) begin
                strb.setPass = 1'b1;
                stateNext    = ST_IDLE;
              end else if (triesLast) begin
                strb.setFail = 1'b1;
                stateNext    = ST_IDLE;
              end else begin
                strb.incTries = 1'b1;
                stateNext     = ST_ISSUE;
              end
            end
          endcase
        end
      end
      ST_HOLD: begin
        strb.incTick = 1'b1;
        if (holdDone) stateNext = ST_ISSUE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign regReq = (state == ST_ISSUE);
  assign busy   = (state != ST_IDLE);

  assert_req_then_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    regReq |=> !regReq);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !regReq);

  assert_op_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(opCur));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (downReq || upReq || checkReq)) |=> busy);

endmodule

// File: rtl/link_seq_top.sv
module link_seq_top
  import link_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned POLL_WAIT     = 100000,
  parameter int unsigned HOLD_CYCLES   = 500000,
  parameter int unsigned MAX_RETRY     = 100,
  parameter int unsigned LINK_TRIES    = 100,
  parameter logic [31:0] SETTINGS_BASE = 32'h3000_3510,
  parameter logic [31:0] CTRL_BASE     = 32'h0000_0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              downReq,
  input  logic              upReq,
  input  logic              checkReq,
  input  logic              regDone,
  input  logic              regDataRdy,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              busy,
  output logic              linkPass,
  output logic              linkFail,
  output logic              timeoutErr
);

  seqStrobeT strb;
  seqOpE     opSel;
  seqOpE     opCur;
  logic      waitDone;
  logic      holdDone;
  logic      retryLast;
  logic      triesLast;
  logic      stepHold;
  logic      stepLast;
  logic      statusMatch;

  link_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .downReq     (downReq),
    .upReq       (upReq),
    .checkReq    (checkReq),
    .regDone     (regDone),
    .regDataRdy  (regDataRdy),
    .opCur       (opCur),
    .waitDone    (waitDone),
    .holdDone    (holdDone),
    .retryLast   (retryLast),
    .triesLast   (triesLast),
    .stepHold    (stepHold),
    .stepLast    (stepLast),
    .statusMatch (statusMatch),
    .strb        (strb),
    .opSel       (opSel),
    .regReq      (regReq),
    .busy        (busy)
  );

  link_seq_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .POLL_WAIT     (POLL_WAIT),
    .HOLD_CYCLES   (HOLD_CYCLES),
    .MAX_RETRY     (MAX_RETRY),
    .LINK_TRIES    (LINK_TRIES),
    .SETTINGS_BASE (SETTINGS_BASE),
    .CTRL_BASE     (CTRL_BASE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .opSel       (opSel),
    .rdData      (regRdData),
    .opCur       (opCur),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regWrite    (regWrite),
    .waitDone    (waitDone),
    .holdDone    (holdDone),
    .retryLast   (retryLast),
    .triesLast   (triesLast),
    .stepHold    (stepHold),
    .stepLast    (stepLast),
    .statusMatch (statusMatch),
    .passFlag    (linkPass),
    .failFlag    (linkFail),
    .errFlag     (timeoutErr)
  );

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutErr && busy) |=> timeoutErr);

endmodule

// File: tb/link_seq_top_bench.sv
module link_seq_top_bench;

  localparam int PW    = 3;
  localparam int HOLD  = 12;
  localparam int RETRY = 4;
  localparam int TRIES = 5;
  localparam logic [31:0] SBASE = 32'h3000_3510;
  localparam logic [31:0] CBASE = 32'h0000_0018;
  localparam logic [31:0] GOOD  = 32'h0F00_9000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic downReq = 1'b0, upReq = 1'b0, checkReq = 1'b0;
  logic regDone, regDataRdy;
  logic [31:0] regRdData;
  logic regReq, regWrite, busy, linkPass, linkFail, timeoutErr;
  logic [7:0] regAddr;
  logic [31:0] regWrData;

  always #5 clk = ~clk;

  link_seq_top #(
    .POLL_WAIT(PW), .HOLD_CYCLES(HOLD), .MAX_RETRY(RETRY), .LINK_TRIES(TRIES),
    .SETTINGS_BASE(SBASE), .CTRL_BASE(CBASE)
  ) u_link_seq_top (
    .clk(clk), .rstN(rstN), .downReq(downReq), .upReq(upReq), .checkReq(checkReq),
    .regDone(regDone), .regDataRdy(regDataRdy), .regRdData(regRdData),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWrData(regWrData),
    .busy(busy), .linkPass(linkPass), .linkFail(linkFail), .timeoutErr(timeoutErr)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Link controller stand-in
  int lat = 1;           // cycles after request until done, negative: never
  int goodAfter = 1;     // status read number that first returns the good word
  logic [31:0] badWord = 32'h0000_1000;
  int since = 0;
  int readCnt = 0;
  int writeCnt = 0;
  logic [31:0] firstAddr = '0;
  logic [31:0] firstData = '0;

  always @(posedge clk) begin
    if (regReq) begin
      since <= 0;
      if (!regWrite) readCnt <= readCnt + 1;
      else begin
        if (writeCnt == 0) begin
          firstAddr <= 32'(regAddr);
          firstData <= regWrData;
        end
        writeCnt <= writeCnt + 1;
      end
    end else if (since < 100000) since <= since + 1;
  end

  assign regDone    = (lat >= 0) && (since >= lat);
  assign regDataRdy = regDone;
  assign regRdData  = (readCnt >= goodAfter) ? GOOD : badWord;

  // Behavioural reference model
  typedef struct { logic [7:0] addr; logic [31:0] data; bit wr; } accT;
  accT expQ[$];
  int mPhase = 0;   // 0 idle, 1 request, 2 wait, 3 poll, 4 hold
  int mCnt = 0, mRetry = 0, mTries = 0, mOp = 0;
  bit mPass = 0, mFail = 0, mErr = 0;

  function automatic accT mk(int a, logic [31:0] d, bit w);
    accT x;
    x.addr = 8'(a); x.data = d; x.wr = w;
    return x;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mPass = 0; mFail = 0; mErr = 0; expQ.delete();
    end else begin
      case (mPhase)
        0: if (downReq || upReq || checkReq) begin
             mPass = 0; mFail = 0; mErr = 0; mTries = 0; expQ.delete();
             if (downReq) begin
               mOp = 0;
               expQ.push_back(mk(8, SBASE & ~32'h2, 1));
               expQ.push_back(mk(7, CBASE | 32'h0500_0000, 1));
               expQ.push_back(mk(4, 32'h0, 1));
               expQ.push_back(mk(5, 32'h0, 1));
               expQ.push_back(mk(7, (CBASE | 32'h0100_0000) & ~32'h0400_0000, 1));
             end else if (upReq) begin
               mOp = 1;
               expQ.push_back(mk(8, SBASE | 32'h2, 1));
             end else begin
               mOp = 2;
               expQ.push_back(mk(5, 32'h0, 0));
             end
             mPhase = 1;
           end
        1: begin mPhase = 2; mCnt = 0; mRetry = 0; end
        2: begin if (mCnt == PW - 1) mPhase = 3; else mCnt++; end
        3: begin
             bit ok;
             ok = regDone && (mOp != 2 || regDataRdy);
             if (!ok && mRetry < RETRY - 1) begin
               mRetry++; mCnt = 0; mPhase = 2;
             end else begin
               if (!ok) mErr = 1;
               if (mOp == 0) begin
                 void'(expQ.pop_front());
                 if (expQ.size() == 0) mPhase = 0;
                 else if (expQ.size() == 1) begin mPhase = 4; mCnt = 0; end
                 else mPhase = 1;
               end else if (mOp == 1) begin
                 void'(expQ.pop_front());
                 mPhase = 0;
               end else if (ok && regRdData == GOOD) begin
                 mPass = 1; mPhase = 0;
               end else if (mTries == TRIES - 1) begin
                 mFail = 1; mPhase = 0;
               end else begin
                 mTries++; mPhase = 1;
               end
             end
           end
        4: begin if (mCnt == HOLD - 1) mPhase = 1; else mCnt++; end
        default: mPhase = 0;
      endcase
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(busy == (mPhase != 0), "R11 busy trace", 32'(busy), 32'(mPhase != 0));
      check(regReq == (mPhase == 1), "R5 request timing", 32'(regReq), 32'(mPhase == 1));
      if (regReq && mPhase == 1 && expQ.size() > 0) begin
        check(regAddr == expQ[0].addr, "R3 access address", 32'(regAddr), 32'(expQ[0].addr));
        check(regWrData == expQ[0].data, "R3 access data", regWrData, expQ[0].data);
        check(regWrite == expQ[0].wr, "R7 access direction", 32'(regWrite), 32'(expQ[0].wr));
      end
      check(linkPass == mPass, "R8 pass flag", 32'(linkPass), 32'(mPass));
      check(linkFail == mFail, "R9 fail flag", 32'(linkFail), 32'(mFail));
      check(timeoutErr == mErr, "R6 error flag", 32'(timeoutErr), 32'(mErr));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic request(bit d, bit u, bit c);
    @(negedge clk);
    writeCnt = 0; readCnt = 0;
    downReq = d; upReq = u; checkReq = c;
    @(negedge clk);
    downReq = 0; upReq = 0; checkReq = 0;
    check(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'h1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !regReq && !linkPass && !linkFail && !timeoutErr, "R1 reset state",
          {27'h0, busy, regReq, linkPass, linkFail, timeoutErr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Bring-down, prompt completion
    lat = 1;
    request(1, 0, 0);
    check(writeCnt == 5, "R3 five writes", 32'(writeCnt), 32'd5);
    check(!timeoutErr, "R6 no timeout", 32'(timeoutErr), 32'h0);

    // Bring-up
    request(0, 1, 0);
    check(writeCnt == 1, "R7 single write", 32'(writeCnt), 32'd1);
    check(firstData[1] == 1'b1, "R7 auto-link set", firstData, SBASE | 32'h2);

    // Health check that passes on the third read
    goodAfter = 3;
    request(0, 0, 1);
    check(linkPass && !linkFail, "R8 pass", {30'h0, linkPass, linkFail}, 32'h2);
    check(readCnt == 3, "R9 read count to pass", 32'(readCnt), 32'd3);

    // Health check that never matches
    goodAfter = 1000;
    request(0, 0, 1);
    check(linkFail && !linkPass, "R9 fail after tries", {30'h0, linkPass, linkFail}, 32'h1);
    check(readCnt == TRIES, "R9 read count limit", 32'(readCnt), 32'(TRIES));

    // Near miss: one extra bit in the status word
    goodAfter = 1000; badWord = GOOD | 32'h1;
    request(0, 0, 1);
    check(linkFail, "R8 exact match required", 32'(linkFail), 32'h1);
    badWord = 32'h0000_1000;

    // Slow completion needs a second poll
    lat = 5;
    request(0, 1, 0);
    check(!timeoutErr, "R5 second poll completes", 32'(timeoutErr), 32'h0);

    // Never completes: timeout but series finishes
    lat = -1;
    request(1, 0, 0);
    check(timeoutErr, "R6 timeout flagged", 32'(timeoutErr), 32'h1);
    check(writeCnt == 5, "R6 series continues", 32'(writeCnt), 32'd5);

    // New request clears flags
    lat = 1; goodAfter = 1;
    request(0, 0, 1);
    check(!timeoutErr && linkPass, "R11 flags cleared", {30'h0, timeoutErr, linkPass}, 32'h1);

    // All three requests in one cycle: bring-down wins
    request(1, 1, 1);
    check(writeCnt == 5 && firstAddr == 8, "R2 down wins", firstAddr, 32'd8);
    check(firstData[1] == 1'b0, "R2 down data first", firstData, SBASE & ~32'h2);

    // Bring-up and check together: bring-up wins
    request(0, 1, 1);
    check(writeCnt == 1 && readCnt == 0, "R2 up over check", 32'(readCnt), 32'd0);

    // Requests while busy are ignored
    fork
      request(1, 0, 0);
      begin
        repeat (8) @(negedge clk);
        upReq = 1; checkReq = 1;
        @(negedge clk);
        upReq = 0; checkReq = 0;
        repeat (HOLD) @(negedge clk);
        downReq = 1;
        @(negedge clk);
        downReq = 0;
      end
    join
    check(writeCnt == 5 && readCnt == 0, "R10 busy requests ignored", 32'(writeCnt), 32'd5);
    repeat (4) @(negedge clk);
    check(!busy, "R10 no late start", 32'(busy), 32'h0);

    // Hold length: measured from fourth write completion in a bring-down
    begin
      int gap;
      int reqs;
      gap = 0; reqs = 0;
      @(negedge clk);
      writeCnt = 0;
      downReq = 1;
      @(negedge clk);
      downReq = 0;
      while (reqs < 4) begin
        if (regReq) reqs++;
        @(negedge clk);
      end
      repeat (PW + 1) @(negedge clk);
      while (!regReq) begin gap++; @(negedge clk); end
      check(gap == HOLD, "R4 hold length", 32'(gap), 32'(HOLD));
      while (busy) @(negedge clk);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule